// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block computes where instruction fetch goes next in a 32-bit RISC core that uses fixed 4-byte instructions in byte-addressed memory. Each cycle it may be given one decoded instruction: the current PC, a control-transfer kind, the sign-extended short branch offset and the wide jump offset, the value of a source register, and the compare bit from the floating-point status register. It returns the next PC, whether the flow was redirected, and for call instructions a return address with a write strobe for the link register.

Every transfer except the register-indirect ones is relative to the address after the current instruction. Conditional branches test only whether one register is zero or non-zero, or test the floating-point compare bit in either sense. The unconditional jumps use the wide offset. The register-indirect jumps take their target from the source register, which allows a return. All results are registered, so each one appears one clock after its input.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `npc_o` becomes `RESET_PC` (0 by default) and `taken_o`, `link_we_o`, `misalign_o` and `out_valid_o` become 0.
- R2: A stimulus presented with `valid_i` high at one rising edge shows on every output just after that edge, with `out_valid_o` high. The outputs do not change before that edge.
- R3: Kind 0 (no transfer) and every undefined kind (9 to 15) give `npc_o` = PC+4 and `taken_o` = 0.
- R4: Kind 1 (branch if register zero) is taken when `rs_val_i` is 0, with target PC+4+sign-extended `boff_i`. Otherwise `npc_o` = PC+4 and `taken_o` = 0.
- R5: Kind 2 (branch if register non-zero) is taken when `rs_val_i` is not 0, with the same target rule as R4.
- R6: Kind 3 is taken when `fcmp_i` is 1 and kind 4 is taken when `fcmp_i` is 0, with the same target rule as R4.
- R7: Kinds 5 (jump) and 6 (jump and link) are always taken, with target PC+4+sign-extended `joff_i`. `boff_i` has no effect on them.
- R8: Kinds 7 (register jump) and 8 (register jump and link) are always taken, with target `rs_val_i`.
- R9: Kinds 6 and 8 set `link_we_o` to 1, `link_o` to PC+4 and `link_rd_o` to 31. No other kind sets `link_we_o`.
- R10: `misalign_o` is 1 only when the transfer is taken and bits [1:0] of the target are not both zero. A branch that is not taken never sets it.
- R11: With `valid_i` low, `taken_o`, `link_we_o`, `misalign_o` and `out_valid_o` become 0 and `npc_o` keeps its value.
- R12: All address sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Stimulus present this cycle |
| pc_i | input | 32 | Address of the current instruction |
| xfer_i | input | 4 | Control-transfer kind (0 to 8; other values mean no transfer) |
| boff_i | input | 16 | Branch byte offset, two's complement |
| joff_i | input | 26 | Jump byte offset, two's complement |
| rs_val_i | input | 32 | Source register value |
| fcmp_i | input | 1 | Floating-point compare bit |
| npc_o | output | 32 | Next PC |
| taken_o | output | 1 | Flow was redirected |
| link_o | output | 32 | Return address for calls |
| link_we_o | output | 1 | Write `link_o` to the link register |
| link_rd_o | output | 5 | Link register index |
| misalign_o | output | 1 | Taken target not 4-byte aligned |
| out_valid_o | output | 1 | Outputs hold a fresh result |

## Verification
Every result (next PC, taken flag, link value and strobe, misalign flag, valid) is due at the first rising edge after the cycle that carries its stimulus. None of them is due earlier. The bench drives inputs on the falling edge and checks them 1 ns after the following rising edge. In the directed latency test it also checks, before that edge, that the outputs still hold the previous result. The idle test drops `valid_i` and checks one edge later that the flags have cleared and the next PC has not moved.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [3:0] {
    XF_NONE  = 4'd0,
    XF_BRZ   = 4'd1,
    XF_BRNZ  = 4'd2,
    XF_FPT   = 4'd3,
    XF_FPF   = 4'd4,
    XF_JMP   = 4'd5,
    XF_CALL  = 4'd6,
    XF_RJMP  = 4'd7,
    XF_RCALL = 4'd8
  } xfer_e;

  typedef enum logic [1:0] {
    TSEL_SEQ = 2'd0,
    TSEL_BR  = 2'd1,
    TSEL_JMP = 2'd2,
    TSEL_REG = 2'd3
  } tsel_e;

endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [3:0]      xfer,
  input  logic [XLEN-1:0] rs_val,
  input  logic            fcmp,
  output logic            taken,
  output logic            is_call,
  output tsel_e           tsel
);

  logic rs_zero;
  assign rs_zero = (rs_val == '0);

  always_comb begin
    taken   = 1'b0;
    is_call = 1'b0;
    tsel    = TSEL_SEQ;
    case (xfer_e'(xfer))
      XF_BRZ:   begin taken = rs_zero;  tsel = TSEL_BR;  end
      XF_BRNZ:  begin taken = !rs_zero; tsel = TSEL_BR;  end
      XF_FPT:   begin taken = fcmp;     tsel = TSEL_BR;  end
      XF_FPF:   begin taken = !fcmp;    tsel = TSEL_BR;  end
      XF_JMP:   begin taken = 1'b1;     tsel = TSEL_JMP; end
      XF_CALL:  begin taken = 1'b1;     tsel = TSEL_JMP; is_call = 1'b1; end
      XF_RJMP:  begin taken = 1'b1;     tsel = TSEL_REG; end
      XF_RCALL: begin taken = 1'b1;     tsel = TSEL_REG; is_call = 1'b1; end
      default:  begin taken = 1'b0;     tsel = TSEL_SEQ; end
    endcase
    if (!taken) tsel = TSEL_SEQ;
  end

endmodule

// File: rtl/npc_target_calc.sv
module npc_target_calc
  import npc_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int BOFF_W      = 16,
  parameter int JOFF_W      = 26,
  parameter int INSTR_BYTES = 4
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [BOFF_W-1:0] boff,
  input  logic [JOFF_W-1:0] joff,
  input  logic [XLEN-1:0]   rs_val,
  input  tsel_e             tsel,
  output logic [XLEN-1:0]   seq_pc,
  output logic [XLEN-1:0]   target
);

  localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

  logic [XLEN-1:0] boff_sx;
  logic [XLEN-1:0] joff_sx;

  assign boff_sx = {{(XLEN-BOFF_W){boff[BOFF_W-1]}}, boff};
  assign joff_sx = {{(XLEN-JOFF_W){joff[JOFF_W-1]}}, joff};
  assign seq_pc  = pc + STEP;

  always_comb begin
    case (tsel)
      TSEL_BR:  target = seq_pc + boff_sx;
      TSEL_JMP: target = seq_pc + joff_sx;
      TSEL_REG: target = rs_val;
      default:  target = seq_pc;
    endcase
  end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter int              BOFF_W      = 16,
  parameter int              JOFF_W      = 26,
  parameter int              REG_AW      = 5,
  parameter int              LINK_REG    = 31,
  parameter int              INSTR_BYTES = 4,
  parameter logic [XLEN-1:0] RESET_PC    = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [3:0]        xfer_i,
  input  logic [BOFF_W-1:0] boff_i,
  input  logic [JOFF_W-1:0] joff_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic              fcmp_i,
  output logic [XLEN-1:0]   npc_o,
  output logic              taken_o,
  output logic [XLEN-1:0]   link_o,
  output logic              link_we_o,
  output logic [REG_AW-1:0] link_rd_o,
  output logic              misalign_o,
  output logic              out_valid_o
);

  localparam int ALIGN_BITS = $clog2(INSTR_BYTES);

  logic            c_taken;
  logic            c_call;
  tsel_e           c_tsel;
  logic [XLEN-1:0] c_seq;
  logic [XLEN-1:0] c_target;
  logic            c_misalign;

  npc_cond_eval #(.XLEN(XLEN)) u_cond (
    .xfer    (xfer_i),
    .rs_val  (rs_val_i),
    .fcmp    (fcmp_i),
    .taken   (c_taken),
    .is_call (c_call),
    .tsel    (c_tsel)
  );

  npc_target_calc #(
    .XLEN        (XLEN),
    .BOFF_W      (BOFF_W),
    .JOFF_W      (JOFF_W),
    .INSTR_BYTES (INSTR_BYTES)
  ) u_tgt (
    .pc     (pc_i),
    .boff   (boff_i),
    .joff   (joff_i),
    .rs_val (rs_val_i),
    .tsel   (c_tsel),
    .seq_pc (c_seq),
    .target (c_target)
  );

  generate
    if (ALIGN_BITS > 0) begin : g_align
      assign c_misalign = c_taken && (c_target[ALIGN_BITS-1:0] != '0);
    end else begin : g_noalign
      assign c_misalign = 1'b0;
    end
  endgenerate

  assign link_rd_o = REG_AW'(LINK_REG);

  always_ff @(posedge clk) begin
    if (rst) begin
      npc_o       <= RESET_PC;
      taken_o     <= 1'b0;
      link_o      <= '0;
      link_we_o   <= 1'b0;
      misalign_o  <= 1'b0;
      out_valid_o <= 1'b0;
    end else if (valid_i) begin
      npc_o       <= c_target;
      taken_o     <= c_taken;
      link_o      <= c_seq;
      link_we_o   <= c_call;
      misalign_o  <= c_misalign;
      out_valid_o <= 1'b1;
    end else begin
      taken_o     <= 1'b0;
      link_we_o   <= 1'b0;
      misalign_o  <= 1'b0;
      out_valid_o <= 1'b0;
    end
  end

endmodule

// File: rtl/npc_unit_sva.sv
module npc_unit_sva #(
  parameter int XLEN   = 32,
  parameter int BOFF_W = 16,
  parameter int JOFF_W = 26,
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              valid_i,
  input logic [XLEN-1:0]   pc_i,
  input logic [3:0]        xfer_i,
  input logic [BOFF_W-1:0] boff_i,
  input logic [JOFF_W-1:0] joff_i,
  input logic [XLEN-1:0]   rs_val_i,
  input logic              fcmp_i,
  input logic [XLEN-1:0]   npc_o,
  input logic              taken_o,
  input logic [XLEN-1:0]   link_o,
  input logic              link_we_o,
  input logic [REG_AW-1:0] link_rd_o,
  input logic              misalign_o,
  input logic              out_valid_o
);

  // R2: a result follows every accepted stimulus one edge later
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> out_valid_o);

  // R11: no stimulus leaves the next PC in place and clears the flags
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(npc_o) && !taken_o && !link_we_o && !out_valid_o));

  // R3: a result that is not taken is the sequential address
  a_r3_seq_when_not_taken: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !taken_o) |-> (npc_o == $past(pc_i) + 32'd4));

  // R9: a link write carries the return address and comes only with a taken transfer
  a_r9_link_value: assert property (@(posedge clk) disable iff (rst)
    link_we_o |-> (taken_o && out_valid_o && link_o == $past(pc_i) + 32'd4));

  // R10: only taken transfers can be flagged misaligned
  a_r10_misalign_taken: assert property (@(posedge clk) disable iff (rst)
    misalign_o |-> taken_o);

  // R9: the link register index is constant
  a_r9_link_rd: assert property (@(posedge clk) disable iff (rst)
    link_rd_o == REG_AW'(31));

endmodule

bind npc_unit npc_unit_sva #(
  .XLEN   (XLEN),
  .BOFF_W (BOFF_W),
  .JOFF_W (JOFF_W),
  .REG_AW (REG_AW)
) u_sva (.*);

// File: tb/npc_unit_tb_top.sv
`timescale 1ns/1ps
module npc_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [31:0] pc_i = '0;
  logic [3:0]  xfer_i = '0;
  logic [15:0] boff_i = '0;
  logic [25:0] joff_i = '0;
  logic [31:0] rs_val_i = '0;
  logic        fcmp_i = 1'b0;
  logic [31:0] npc_o;
  logic        taken_o;
  logic [31:0] link_o;
  logic        link_we_o;
  logic [4:0]  link_rd_o;
  logic        misalign_o;
  logic        out_valid_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  npc_unit dut_i (
    .clk(clk), .rst(rst), .valid_i(valid_i), .pc_i(pc_i), .xfer_i(xfer_i),
    .boff_i(boff_i), .joff_i(joff_i), .rs_val_i(rs_val_i), .fcmp_i(fcmp_i),
    .npc_o(npc_o), .taken_o(taken_o), .link_o(link_o), .link_we_o(link_we_o),
    .link_rd_o(link_rd_o), .misalign_o(misalign_o), .out_valid_o(out_valid_o)
  );

  typedef struct packed {
    logic [3:0]  xf;
    logic [31:0] pc;
    logic [15:0] bo;
    logic [25:0] jo;
    logic [31:0] rs;
    logic        fc;
    logic [31:0] e_npc;
    logic        e_tk;
    logic        e_we;
    logic        e_mis;
    logic [31:0] e_link;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 32'h0000_0100, 16'h0000, 26'h0000000, 32'h0,         1'b0, 32'h0000_0104, 1'b0, 1'b0, 1'b0, 32'h0},         // R3
    '{4'd1, 32'h0000_1000, 16'h0010, 26'h0000000, 32'h0,         1'b0, 32'h0000_1014, 1'b1, 1'b0, 1'b0, 32'h0},         // R4 taken
    '{4'd1, 32'h0000_1000, 16'h0010, 26'h0000000, 32'h5,         1'b0, 32'h0000_1004, 1'b0, 1'b0, 1'b0, 32'h0},         // R4 not taken
    '{4'd1, 32'h0000_2000, 16'hFFF0, 26'h0000000, 32'h0,         1'b0, 32'h0000_1FF4, 1'b1, 1'b0, 1'b0, 32'h0},         // R4 backward
    '{4'd2, 32'h0000_3000, 16'h0100, 26'h0000000, 32'h1,         1'b0, 32'h0000_3104, 1'b1, 1'b0, 1'b0, 32'h0},         // R5 taken
    '{4'd2, 32'h0000_3000, 16'h0100, 26'h0000000, 32'h0,         1'b0, 32'h0000_3004, 1'b0, 1'b0, 1'b0, 32'h0},         // R5 not taken
    '{4'd3, 32'h0000_0400, 16'h0020, 26'h0000000, 32'h0,         1'b1, 32'h0000_0424, 1'b1, 1'b0, 1'b0, 32'h0},         // R6
    '{4'd3, 32'h0000_0400, 16'h0020, 26'h0000000, 32'h0,         1'b0, 32'h0000_0404, 1'b0, 1'b0, 1'b0, 32'h0},         // R6
    '{4'd4, 32'h0000_0400, 16'h0020, 26'h0000000, 32'h0,         1'b0, 32'h0000_0424, 1'b1, 1'b0, 1'b0, 32'h0},         // R6
    '{4'd4, 32'h0000_0400, 16'h0020, 26'h0000000, 32'h0,         1'b1, 32'h0000_0404, 1'b0, 1'b0, 1'b0, 32'h0},         // R6
    '{4'd5, 32'h0001_0000, 16'h8000, 26'h0001000, 32'h0,         1'b0, 32'h0001_1004, 1'b1, 1'b0, 1'b0, 32'h0},         // R7
    '{4'd5, 32'h0001_0000, 16'h0000, 26'h3FFFFFC, 32'h0,         1'b0, 32'h0001_0000, 1'b1, 1'b0, 1'b0, 32'h0},         // R7 backward
    '{4'd6, 32'h0000_0500, 16'h0040, 26'h0000100, 32'h0,         1'b0, 32'h0000_0604, 1'b1, 1'b1, 1'b0, 32'h0000_0504}, // R9 call
    '{4'd7, 32'h0000_0700, 16'h0000, 26'h0000000, 32'h00AB_CDE0, 1'b0, 32'h00AB_CDE0, 1'b1, 1'b0, 1'b0, 32'h0},         // R8
    '{4'd8, 32'h0000_0900, 16'h0000, 26'h0000000, 32'h0000_8000, 1'b0, 32'h0000_8000, 1'b1, 1'b1, 1'b0, 32'h0000_0904}, // R9 reg call
    '{4'd1, 32'h0000_0100, 16'h0002, 26'h0000000, 32'h0,         1'b0, 32'h0000_0106, 1'b1, 1'b0, 1'b1, 32'h0},         // R10
    '{4'd1, 32'h0000_0100, 16'h0003, 26'h0000000, 32'h1,         1'b0, 32'h0000_0104, 1'b0, 1'b0, 1'b0, 32'h0},         // R10 not taken
    '{4'd7, 32'h0000_0100, 16'h0000, 26'h0000000, 32'h0000_1001, 1'b0, 32'h0000_1001, 1'b1, 1'b0, 1'b1, 32'h0},         // R10 reg
    '{4'd0, 32'hFFFF_FFFC, 16'h0000, 26'h0000000, 32'h0,         1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'h0},         // R12
    '{4'd15,32'h0000_0040, 16'h0010, 26'h0000010, 32'h0,         1'b0, 32'h0000_0044, 1'b0, 1'b0, 1'b0, 32'h0}          // R3 undefined
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    valid_i = 1'b1; xfer_i = v.xf; pc_i = v.pc; boff_i = v.bo;
    joff_i = v.jo; rs_val_i = v.rs; fcmp_i = v.fc;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 npc", npc_o, 32'h0);
    chk("R1 flags", {28'h0, taken_o, link_we_o, misalign_o, out_valid_o}, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      chk($sformatf("vec%0d npc", i),   npc_o, VECS[i].e_npc);
      chk($sformatf("vec%0d taken", i), {31'h0, taken_o}, {31'h0, VECS[i].e_tk});
      chk($sformatf("vec%0d R9 link_we", i), {31'h0, link_we_o}, {31'h0, VECS[i].e_we});
      chk($sformatf("vec%0d R10 misalign", i), {31'h0, misalign_o}, {31'h0, VECS[i].e_mis});
      chk($sformatf("vec%0d R2 valid", i), {31'h0, out_valid_o}, 32'h1);
      if (VECS[i].e_we) begin
        chk($sformatf("vec%0d R9 link", i), link_o, VECS[i].e_link);
        chk($sformatf("vec%0d R9 rd", i), {27'h0, link_rd_o}, 32'd31);
      end
    end

    // R2 latency: outputs unchanged before the edge
    @(negedge clk);
    valid_i = 1'b1; xfer_i = 4'd5; pc_i = 32'h0000_2000; joff_i = 26'h0000020; boff_i = '0;
    #1;
    chk("R2 before edge", npc_o, 32'h0000_0044);
    @(posedge clk);
    #1;
    chk("R2 after edge", npc_o, 32'h0000_2024);
    chk("R2 taken", {31'h0, taken_o}, 32'h1);

    // R11 idle: call kind presented with valid low
    @(negedge clk);
    valid_i = 1'b0; xfer_i = 4'd6; pc_i = 32'h0000_8000; joff_i = 26'h0000100;
    @(posedge clk);
    #1;
    chk("R11 npc hold", npc_o, 32'h0000_2024);
    chk("R11 flags", {28'h0, taken_o, link_we_o, misalign_o, out_valid_o}, 32'h0);

    // R1 reset after activity
    @(negedge clk);
    valid_i = 1'b1; rst = 1'b1; xfer_i = 4'd7; rs_val_i = 32'h0000_0003;
    @(posedge clk);
    #1;
    chk("R1 npc again", npc_o, 32'h0);
    chk("R1 flags again", {28'h0, taken_o, link_we_o, misalign_o, out_valid_o}, 32'h0);
    @(negedge clk);
    rst = 1'b0; valid_i = 1'b0;
    @(posedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule